// File: doc/BRIEF.md
# RV64 word-operation execution unit

This unit decodes and executes the integer operations that a 64-bit RISC-V core adds on top of the 32-bit base set. The operations fall into two groups. The first is the full-width immediate shifts, which take a 6-bit shift amount. The second is the "word" add, subtract and shift operations in immediate and register form. A word operation computes on the low 32 bits of its operands and widens the 32-bit result to 64 bits by copying bit 31 into the upper half.

Each cycle the unit takes a 32-bit instruction word and two 64-bit source operand values. It returns a destination register index, a write enable, a 64-bit result and an illegal-instruction flag. All four outputs are registered and appear one clock after the inputs.

Opcodes outside the three the unit owns are left to other execution units. For those opcodes the unit stays quiet: no write and no illegal flag.

Top module: `rvw_exec_unit`

## Requirements
- R1: Opcode 0010011 with funct3 001 and instruction bits 31:26 equal to 000000 produces src1 shifted left by instruction bits 25:20 (0 to 63). Vacated bits are zero.
- R2: Opcode 0010011 with funct3 101 shifts src1 right by bits 25:20. Bits 31:26 equal to 000000 select a zero-filled shift. Bits 31:26 equal to 010000 select a shift that fills with bit 63.
- R3: Opcode 0011011 with funct3 000 adds the sign-extended 12-bit immediate in bits 31:20 to src1[31:0], modulo 2^32. The upper half of src1 has no effect.
- R4: Opcode 0011011 with funct3 001 (bits 31:25 = 0000000) shifts src1[31:0] left. With funct3 101, bits 31:25 = 0000000 select a zero-filled right shift and 0100000 selects an arithmetic right shift. In all three the shift amount is bits 24:20.
- R5: Opcode 0111011 with funct3 000 computes src1[31:0] + src2[31:0] when funct7 is 0000000, and src1[31:0] - src2[31:0] when funct7 is 0100000. Both are taken modulo 2^32.
- R6: Opcode 0111011 with funct3 001 (funct7 0000000) is a word left shift. With funct3 101, funct7 0000000 selects a zero-filled word right shift and 0100000 selects an arithmetic one. The count is src2[4:0], and src2[63:5] has no effect.
- R7: Every word operation widens its 32-bit result to 64 bits by copying bit 31 into bits 63:32. An arithmetic word right shift fills with src1 bit 31, never with bit 63.
- R8: For a recognised operation, rd_o carries instruction bits 11:7 and result_o carries the computed value. wen_o is 1 exactly when that index is non-zero.
- R9: In the three owned opcodes, any funct3/funct7 (or bits 31:26) combination not listed in R1 to R6 is illegal. For such an encoding illegal_o is 1 and wen_o, rd_o and result_o are 0. A left shift with 010000 in bits 31:26 is illegal.
- R10: For any other opcode, or for opcode 0010011 with a funct3 other than 001 or 101, all four outputs are 0.
- R11: Outputs change only on the rising clock edge and reflect the inputs sampled at that edge. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| src1_i | input | 64 | First source operand value |
| src2_i | input | 64 | Second source operand value |
| rd_o | output | 5 | Destination register index |
| wen_o | output | 1 | Destination write enable |
| result_o | output | 64 | Result value |
| illegal_o | output | 1 | Illegal encoding in an owned opcode |

## Verification
The bench builds the unit with its default widths: a 64-bit datapath and a 32-bit word. With these widths the upper half of every operand differs from the low half, so the bench can observe several things directly. It can see whether a result was widened from bit 31 or from bit 63. It can see whether an operand's upper half leaked into a word operation. It can also tell a 6-bit immediate shift apart from a 5-bit masked register count. Shift amounts of 0, 31, 32 and 63 sit at both stage boundaries of the barrel shifters, and these are driven directly, along with mixed random encodings that cross the legality boundaries.

// File: rtl/rvw_pkg.sv
package rvw_pkg;

    localparam logic [6:0] OPC_SHIFT64 = 7'b0010011;
    localparam logic [6:0] OPC_WORD_IM = 7'b0011011;
    localparam logic [6:0] OPC_WORD_RG = 7'b0111011;

    localparam logic [2:0] F3_ADD = 3'b000;
    localparam logic [2:0] F3_SLL = 3'b001;
    localparam logic [2:0] F3_SRX = 3'b101;

    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;
    localparam logic [5:0] F6_BASE = 6'b000000;
    localparam logic [5:0] F6_ALT  = 6'b010000;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_SLL64,
        OP_SRL64,
        OP_SRA64,
        OP_ADDW,
        OP_SUBW,
        OP_SLLW,
        OP_SRLW,
        OP_SRAW
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [4:0]  rd;
        logic        illegal;
        logic [5:0]  shamt;
        logic [11:0] imm;
        logic        use_imm;
    } dec_t;

endpackage

// File: rtl/rvw_decode.sv
module rvw_decode
    import rvw_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;
    logic [5:0] f6;
    logic       unused_rs_field;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];
    assign f6  = instr[31:26];
    assign unused_rs_field = ^instr[19:15];

    always_comb begin
        dec         = '0;
        dec.op      = OP_NONE;
        dec.imm     = instr[31:20];
        dec.shamt   = instr[25:20];
        case (opc)
            OPC_SHIFT64: begin
                if (f3 == F3_SLL) begin
                    if (f6 == F6_BASE) dec.op = OP_SLL64;
                    else               dec.illegal = 1'b1;
                end else if (f3 == F3_SRX) begin
                    if (f6 == F6_BASE)     dec.op = OP_SRL64;
                    else if (f6 == F6_ALT) dec.op = OP_SRA64;
                    else                   dec.illegal = 1'b1;
                end
            end
            OPC_WORD_IM: begin
                dec.use_imm = 1'b1;
                dec.shamt   = {1'b0, instr[24:20]};
                case (f3)
                    F3_ADD: dec.op = OP_ADDW;
                    F3_SLL: begin
                        if (f7 == F7_BASE) dec.op = OP_SLLW;
                        else               dec.illegal = 1'b1;
                    end
                    F3_SRX: begin
                        if (f7 == F7_BASE)     dec.op = OP_SRLW;
                        else if (f7 == F7_ALT) dec.op = OP_SRAW;
                        else                   dec.illegal = 1'b1;
                    end
                    default: dec.illegal = 1'b1;
                endcase
            end
            OPC_WORD_RG: begin
                case (f3)
                    F3_ADD: begin
                        if (f7 == F7_BASE)     dec.op = OP_ADDW;
                        else if (f7 == F7_ALT) dec.op = OP_SUBW;
                        else                   dec.illegal = 1'b1;
                    end
                    F3_SLL: begin
                        if (f7 == F7_BASE) dec.op = OP_SLLW;
                        else               dec.illegal = 1'b1;
                    end
                    F3_SRX: begin
                        if (f7 == F7_BASE)     dec.op = OP_SRLW;
                        else if (f7 == F7_ALT) dec.op = OP_SRAW;
                        else                   dec.illegal = 1'b1;
                    end
                    default: dec.illegal = 1'b1;
                endcase
            end
            default: ;
        endcase
        if (dec.op != OP_NONE) dec.rd = instr[11:7];
    end

    // R9
    legal_excl_chk: assert final (!(dec.illegal && dec.op != OP_NONE));

endmodule

// File: rtl/rvw_shift.sv
module rvw_shift #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   val,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   res
);

    logic [W-1:0] stg [0:SHW];
    logic         fill_bit;

    assign stg[0]   = val;
    assign fill_bit = arith & val[W-1];

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        logic [W-1:0] lsh;
        logic [W-1:0] rsh;
        assign lsh = {stg[k][W-1-STEP:0], {STEP{1'b0}}};
        assign rsh = {{STEP{fill_bit}}, stg[k][W-1:STEP]};
        assign stg[k+1] = !amt[k] ? stg[k] : (left ? lsh : rsh);
    end

    assign res = stg[SHW];

endmodule

// File: rtl/rvw_word_alu.sv
module rvw_word_alu
    import rvw_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    localparam int WSHW = $clog2(WLEN)
) (
    input  op_e             op,
    input  logic [WLEN-1:0] opa,
    input  logic [WLEN-1:0] opb,
    input  logic [WSHW-1:0] amt,
    output logic [XLEN-1:0] res
);

    logic [WLEN-1:0] sum_w;
    logic [WLEN-1:0] shf_w;
    logic [WLEN-1:0] sel_w;

    assign sum_w = (op == OP_SUBW) ? (opa - opb) : (opa + opb);

    rvw_shift #(.W(WLEN), .SHW(WSHW)) u_wshift (
        .val   (opa),
        .amt   (amt),
        .left  (op == OP_SLLW),
        .arith (op == OP_SRAW),
        .res   (shf_w)
    );

    assign sel_w = (op == OP_ADDW || op == OP_SUBW) ? sum_w : shf_w;

    if (XLEN > WLEN) begin : g_widen
        assign res = {{(XLEN-WLEN){sel_w[WLEN-1]}}, sel_w};
    end else begin : g_same
        assign res = sel_w;
    end

endmodule

// File: rtl/rvw_exec_unit.sv
module rvw_exec_unit
    import rvw_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [31:0]     instr_i,
    input  logic [XLEN-1:0] src1_i,
    input  logic [XLEN-1:0] src2_i,
    output logic [RIDX-1:0] rd_o,
    output logic            wen_o,
    output logic [XLEN-1:0] result_o,
    output logic            illegal_o
);

    localparam int SHW  = $clog2(XLEN);
    localparam int WSHW = $clog2(WLEN);
    localparam int IMMW = 12;

    typedef struct packed {
        logic [RIDX-1:0] rd;
        logic            wen;
        logic [XLEN-1:0] result;
        logic            illegal;
        logic            is_word;
    } out_t;

    dec_t            dec;
    out_t            out_d;
    out_t            out_q;
    logic [XLEN-1:0] full_res;
    logic [XLEN-1:0] word_res;
    logic [WLEN-1:0] word_b;
    logic [WSHW-1:0] word_amt;
    logic            is_word_op;
    logic            unused_src2_hi;

    assign unused_src2_hi = ^src2_i[XLEN-1:WLEN];

    rvw_decode u_dec (
        .instr (instr_i),
        .dec   (dec)
    );

    rvw_shift #(.W(XLEN), .SHW(SHW)) u_fshift (
        .val   (src1_i),
        .amt   (dec.shamt[SHW-1:0]),
        .left  (dec.op == OP_SLL64),
        .arith (dec.op == OP_SRA64),
        .res   (full_res)
    );

    assign word_b   = dec.use_imm ? {{(WLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm}
                                  : src2_i[WLEN-1:0];
    assign word_amt = dec.use_imm ? dec.shamt[WSHW-1:0] : src2_i[WSHW-1:0];

    rvw_word_alu #(.XLEN(XLEN), .WLEN(WLEN)) u_walu (
        .op  (dec.op),
        .opa (src1_i[WLEN-1:0]),
        .opb (word_b),
        .amt (word_amt),
        .res (word_res)
    );

    assign is_word_op = (dec.op == OP_ADDW) || (dec.op == OP_SUBW) ||
                        (dec.op == OP_SLLW) || (dec.op == OP_SRLW) ||
                        (dec.op == OP_SRAW);

    always_comb begin
        out_d         = '0;
        out_d.illegal = dec.illegal;
        if (dec.op != OP_NONE) begin
            out_d.rd      = dec.rd;
            out_d.wen     = (dec.rd != '0);
            out_d.is_word = is_word_op;
            out_d.result  = is_word_op ? word_res : full_res;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_o      = out_q.rd;
    assign wen_o     = out_q.wen;
    assign result_o  = out_q.result;
    assign illegal_o = out_q.illegal;

    // R8
    rd0_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_o |-> (rd_o != '0));

    // R9
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!wen_o && rd_o == '0 && result_o == '0));

    // R7
    word_widen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.is_word |-> (result_o[XLEN-1:WLEN] == {(XLEN-WLEN){result_o[WLEN-1]}}));

    // R10
    foreign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[6:0] != OPC_SHIFT64 && instr_i[6:0] != OPC_WORD_IM &&
         instr_i[6:0] != OPC_WORD_RG) |=> (!illegal_o && !wen_o));

    // R11
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wen_o |-> (rd_o == $past(instr_i[11:7])));

endmodule

// File: tb/rvw_exec_unit_bench.sv
`timescale 1ns/1ps
module rvw_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] instr_i;
    logic [63:0] src1_i;
    logic [63:0] src2_i;
    logic [4:0]  rd_o;
    logic        wen_o;
    logic [63:0] result_o;
    logic        illegal_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    typedef struct packed {
        logic [4:0]  rd;
        logic        wen;
        logic [63:0] res;
        logic        ill;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    rvw_exec_unit u_rvw_exec_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_i   (instr_i),
        .src1_i    (src1_i),
        .src2_i    (src2_i),
        .rd_o      (rd_o),
        .wen_o     (wen_o),
        .result_o  (result_o),
        .illegal_o (illegal_o)
    );

    function automatic logic [31:0] enc(input logic [6:0] f7, input logic [4:0] r2,
                                        input logic [4:0] r1, input logic [2:0] f3,
                                        input logic [4:0] rd, input logic [6:0] opc);
        return {f7, r2, r1, f3, rd, opc};
    endfunction

    function automatic exp_t ref_model(input logic [31:0] ins, input logic [63:0] a,
                                       input logic [63:0] b);
        exp_t               e;
        logic [2:0]         f3;
        logic [6:0]         f7;
        logic [31:0]        w;
        logic signed [31:0] sw;
        logic signed [63:0] sa;
        logic [63:0]        v;
        bit                 known;
        bit                 word;
        bit                 bad;
        int                 sh;
        e = '0; f3 = ins[14:12]; f7 = ins[31:25];
        known = 0; word = 0; bad = 0; v = '0; w = '0;
        sw = $signed(a[31:0]); sa = $signed(a);
        case (ins[6:0])
            7'b0010011: begin
                sh = int'(ins[25:20]);
                if (f3 == 3'd1) begin
                    if (ins[31:26] == 6'd0) begin known = 1; v = a << sh; end
                    else bad = 1;
                end else if (f3 == 3'd5) begin
                    if (ins[31:26] == 6'd0) begin known = 1; v = a >> sh; end
                    else if (ins[31:26] == 6'b010000) begin known = 1; v = sa >>> sh; end
                    else bad = 1;
                end
            end
            7'b0011011, 7'b0111011: begin
                bit regf;
                regf = (ins[6:0] == 7'b0111011);
                sh = regf ? int'(b[4:0]) : int'(ins[24:20]);
                word = 1;
                if (f3 == 3'd0 && !regf) begin
                    known = 1; w = a[31:0] + {{20{ins[31]}}, ins[31:20]};
                end else if (f3 == 3'd0 && f7 == 7'd0) begin
                    known = 1; w = a[31:0] + b[31:0];
                end else if (f3 == 3'd0 && f7 == 7'h20) begin
                    known = 1; w = a[31:0] - b[31:0];
                end else if (f3 == 3'd1 && f7 == 7'd0) begin
                    known = 1; w = a[31:0] << sh;
                end else if (f3 == 3'd5 && f7 == 7'd0) begin
                    known = 1; w = a[31:0] >> sh;
                end else if (f3 == 3'd5 && f7 == 7'h20) begin
                    known = 1; w = sw >>> sh;
                end else bad = 1;
                v = {{32{w[31]}}, w};
            end
            default: ;
        endcase
        if (bad) e.ill = 1'b1;
        else if (known) begin
            e.rd = ins[11:7]; e.wen = (ins[11:7] != 0); e.res = v;
        end
        return e;
    endfunction

    task automatic compare_one(input exp_t e, input string tag);
        exp_t got;
        got = '{rd: rd_o, wen: wen_o, res: result_o, ill: illegal_o};
        tests++;
        if (got !== e) begin
            fails++;
            $display("FAIL %s: actual rd=%0d wen=%0b res=%h ill=%0b expected rd=%0d wen=%0b res=%h ill=%0b",
                     tag, got.rd, got.wen, got.res, got.ill, e.rd, e.wen, e.res, e.ill);
        end
    endtask

    task automatic flush_one();
        if (exp_q.size() > 0) compare_one(exp_q.pop_front(), tag_q.pop_front());
    endtask

    task automatic step(input logic [31:0] ins, input logic [63:0] a,
                        input logic [63:0] b, input string tag);
        @(negedge clk);
        flush_one();
        instr_i = ins; src1_i = a; src2_i = b;
        exp_q.push_back(ref_model(ins, a, b));
        tag_q.push_back(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL R11 watchdog: actual=hung expected=completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        instr_i = enc(7'd0, 5'd3, 5'd1, 3'd0, 5'd4, 7'b0111011);
        src1_i = 64'h1234; src2_i = 64'h55;
        repeat (3) begin
            @(negedge clk);
            compare_one('0, "R11 reset");
        end
        rst_n = 1'b1;

        // R1
        step(enc({6'd0, 1'b1}, 5'd31, 5'd1, 3'd1, 5'd5, 7'b0010011), 64'h8000_0000_0000_0001, 0, "R1 slli 63");
        step(enc({6'd0, 1'b0}, 5'd0,  5'd1, 3'd1, 5'd5, 7'b0010011), 64'hDEAD_BEEF_0123_4567, 0, "R1 slli 0");
        step(enc({6'd0, 1'b1}, 5'd0,  5'd1, 3'd1, 5'd6, 7'b0010011), 64'h0000_0000_F000_000F, 0, "R1 slli 32");
        // R2
        step(enc({6'd0, 1'b1}, 5'd31, 5'd1, 3'd5, 5'd7, 7'b0010011), 64'h8000_0000_0000_0000, 0, "R2 srli 63");
        step(enc({6'b010000, 1'b1}, 5'd31, 5'd1, 3'd5, 5'd7, 7'b0010011), 64'h8000_0000_0000_0000, 0, "R2 srai 63");
        step(enc({6'b010000, 1'b0}, 5'd4, 5'd1, 3'd5, 5'd8, 7'b0010011), 64'hF000_0000_0000_00F0, 0, "R2 srai 4");
        step(enc({6'b010000, 1'b1}, 5'd0, 5'd1, 3'd5, 5'd8, 7'b0010011), 64'h7000_0000_8000_0000, 0, "R2 srai 32 pos");
        // R3
        step(enc(7'd0, 5'd1, 5'd1, 3'd0, 5'd9, 7'b0011011), 64'h0000_0000_7FFF_FFFF, 0, "R3 addiw overflow");
        step(enc(7'h7F, 5'h1A, 5'd1, 3'd0, 5'd9, 7'b0011011), 64'hFFFF_FFFF_0000_0005, 0, "R3 addiw neg imm");
        step(enc(7'h3F, 5'h1F, 5'd1, 3'd0, 5'd9, 7'b0011011), 64'hABCD_0000_0000_0001, 0, "R3 addiw hi ignored");
        // R4
        step(enc(7'd0, 5'd31, 5'd1, 3'd1, 5'd10, 7'b0011011), 64'h1, 0, "R4 slliw 31");
        step(enc(7'd0, 5'd0, 5'd1, 3'd5, 5'd10, 7'b0011011), 64'hFFFF_0000_8000_0000, 0, "R4 srliw 0");
        step(enc(7'd0, 5'd4, 5'd1, 3'd5, 5'd10, 7'b0011011), 64'h0000_0000_8000_0000, 0, "R4 srliw 4");
        step(enc(7'h20, 5'd31, 5'd1, 3'd5, 5'd11, 7'b0011011), 64'h0000_0000_8000_0000, 0, "R4 sraiw 31");
        // R5
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd12, 7'b0111011), 64'hFFFF_FFFF_7FFF_FFFF, 64'h1234_0000_0000_0001, "R5 addw overflow");
        step(enc(7'h20, 5'd2, 5'd1, 3'd0, 5'd12, 7'b0111011), 64'h0, 64'h1, "R5 subw underflow");
        step(enc(7'h20, 5'd2, 5'd1, 3'd0, 5'd13, 7'b0111011), 64'h5_0000_0009, 64'h7_0000_0002, "R5 subw pos");
        // R6
        step(enc(7'd0, 5'd2, 5'd1, 3'd1, 5'd14, 7'b0111011), 64'h1, 64'hFFFF_FFFF_FFFF_FFE3, "R6 sllw count mask");
        step(enc(7'd0, 5'd2, 5'd1, 3'd1, 5'd14, 7'b0111011), 64'h1234_5678, 64'h20, "R6 sllw 32 -> 0");
        step(enc(7'd0, 5'd2, 5'd1, 3'd5, 5'd14, 7'b0111011), 64'h8000_0000, 64'h3F, "R6 srlw 31");
        step(enc(7'h20, 5'd2, 5'd1, 3'd5, 5'd15, 7'b0111011), 64'hC000_0000, 64'h41, "R6 sraw 1");
        // R7
        step(enc(7'h20, 5'd2, 5'd1, 3'd5, 5'd16, 7'b0111011), 64'h8000_0000_7000_0000, 64'h4, "R7 sraw bit31 clear");
        step(enc(7'h20, 5'd2, 5'd1, 3'd5, 5'd16, 7'b0111011), 64'h0000_0000_8000_0000, 64'h4, "R7 sraw bit31 set");
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd16, 7'b0111011), 64'h0, 64'hFFFF_FFFF, "R7 addw widen");
        // R8
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd0, 7'b0111011), 64'h3, 64'h4, "R8 addw rd0");
        step(enc({6'd0, 1'b0}, 5'd1, 5'd1, 3'd1, 5'd0, 7'b0010011), 64'h3, 0, "R8 slli rd0");
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd31, 7'b0111011), 64'h3, 64'h4, "R8 addw rd31");
        // R9
        step(enc({6'b010000, 1'b0}, 5'd1, 5'd1, 3'd1, 5'd3, 7'b0010011), 64'h3, 0, "R9 slli alt bits");
        step(enc({6'b000001, 1'b0}, 5'd1, 5'd1, 3'd5, 5'd3, 7'b0010011), 64'h3, 0, "R9 srli bad bits");
        step(enc(7'h20, 5'd1, 5'd1, 3'd1, 5'd3, 7'b0011011), 64'h3, 0, "R9 slliw alt");
        step(enc(7'd1, 5'd1, 5'd1, 3'd5, 5'd3, 7'b0011011), 64'h3, 0, "R9 srliw bit25");
        step(enc(7'd0, 5'd1, 5'd1, 3'd3, 5'd3, 7'b0011011), 64'h3, 0, "R9 immw f3 011");
        step(enc(7'd1, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0111011), 64'h3, 64'h4, "R9 addw f7 01");
        step(enc(7'd0, 5'd2, 5'd1, 3'd2, 5'd3, 7'b0111011), 64'h3, 64'h4, "R9 regw f3 010");
        // R10
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0110011), 64'h3, 64'h4, "R10 other opcode");
        step(enc(7'd0, 5'd2, 5'd1, 3'd0, 5'd3, 7'b0010011), 64'h3, 64'h4, "R10 shift64 f3 000");
        step(enc(7'h7F, 5'd2, 5'd1, 3'd7, 5'd3, 7'b0000011), 64'h3, 64'h4, "R10 load opcode");

        for (int i = 0; i < 400; i++) begin
            logic [6:0]  opc;
            logic [6:0]  f7;
            logic [31:0] r;
            r = $urandom;
            case (r[1:0])
                2'd0: opc = 7'b0010011;
                2'd1: opc = 7'b0011011;
                2'd2: opc = 7'b0111011;
                default: opc = r[8:2];
            endcase
            case (r[10:9])
                2'd0: f7 = 7'd0;
                2'd1: f7 = 7'h20;
                2'd2: f7 = {6'b010000, r[11]};
                default: f7 = r[18:12];
            endcase
            step(enc(f7, r[23:19], r[28:24], r[31:29], 5'(i), opc),
                 {$urandom, $urandom}, {$urandom, $urandom}, "R11 mixed");
        end

        @(negedge clk);
        flush_one();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule